// File: doc/BRIEF.md
# Interrupt crossbar router

The router sits between a wide field of peripheral interrupt sources and a narrower bank of interrupt-controller inputs. Each output line that can be steered owns a small selection register naming the source that drives it. The line then follows that source's level, active high, with no edge detection and no latching. Software programs the selections through a single-cycle write strobe with a byte address and data, and can read any selection back through a combinational read port.

Two kinds of output are fixed at build time through per-output bitmasks. Reserved outputs have no register, take no address and are held low. Bypass outputs keep an address slot but are hardwired: bypass output k always carries source k, and writes to its slot leave it unchanged. The selection registers are packed at consecutive multiples of the register width. Only reserved outputs are skipped, so the address of a register is not a linear function of its output index. After reset, every programmable output carries a configurable safe source. Releasing a route means writing that safe source back.

Bad writes are dropped. A sticky error machine records them and has two states: ERR_CLEAR, the state after reset, and ERR_LATCHED. The only transition is BAD_WRITE, from ERR_CLEAR to ERR_LATCHED, taken on a write to an address that maps to no slot or a write of an out-of-range source index. ERR_LATCHED holds until reset.

Top module: `xbar_irq_router`

## Requirements
- R1: After reset every programmable output (neither reserved nor bypass) selects source SAFE_SRC (default 15), reads back SAFE_SRC, and err_flag is 0.
- R2: REG_BYTES must be 1, 2 or 4 (any other value stops elaboration); the data ports are REG_BYTES*8 bits wide and the slot stride is REG_BYTES bytes (default 2).
- R3: The register of output i sits at byte address REG_BYTES times the number of non-reserved outputs below i; with the defaults (reserved outputs 1 and 4, bypass output 6) the slots of outputs 0, 2, 3, 5, 6 and 7 are at 0, 2, 4, 6, 8 and 10.
- R4: A write of a source index below NUM_SRC to the slot of a programmable output replaces its selection at that clock edge, and the output follows the new source from then on.
- R5: A write whose data is NUM_SRC or more changes no selection and sets err_flag.
- R6: A write to an address that equals no slot address (including misaligned addresses and addresses past the last slot) changes no selection and sets err_flag.
- R7: Bypass output k always drives source k; a valid write to its slot leaves its routing unchanged, its slot reads back k, and err_flag is not set.
- R8: Reserved outputs drive 0 whatever the sources do.
- R9: err_flag, once set, stays at 1 through later valid writes until reset.
- R10: rd_data returns the selection of the slot at rd_addr, zero-extended, and 0 for an address that matches no slot.
- R11: A routed output is level-sensitive: it is 1 while its selected source is 1 and 0 while that source is 0, with no clock delay.
- R12: Writing SAFE_SRC to a routed output releases it back to the safe source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the slot being written |
| wr_data | input | REG_BYTES*8 | Source index to store |
| rd_addr | input | ADDR_W | Byte address of the slot to read |
| rd_data | output | REG_BYTES*8 | Selection at rd_addr, zero for an unmapped address |
| src_irq | input | NUM_SRC | Peripheral interrupt levels |
| out_irq | output | NUM_OUT | Routed interrupt levels toward the controller |
| err_flag | output | 1 | Sticky flag for a rejected write |

## Verification
The hardest cases are writes that hit the gaps in the slot map without the bench copying the map. These are the address in the middle of a two-byte slot, the address just past the last slot, and the slot of the bypass output, which is mapped yet inert. Because err_flag is sticky, each rejected-write case starts from its own reset. After the write, the stimulus reads every programmable slot to show that nothing moved. Routing is checked by driving a single source high and then its complement, so each output can match only the source it selected.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic {
        ERR_CLEAR   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_e;

    // number of set bits of mask strictly below position idx
    function automatic int ones_below(logic [63:0] mask, int idx);
        int n;
        n = 0;
        for (int k = 0; k < 64; k++) begin
            if (k < idx && mask[k]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/xbar_slot_decode.sv
module xbar_slot_decode #(
    parameter int                NUM_OUT       = 8,
    parameter int                REG_BYTES     = 2,
    parameter int                ADDR_W        = 8,
    parameter logic [NUM_OUT-1:0] RESERVED_MASK = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_OUT-1:0] hit,
    output logic               any_hit
);
    import xbar_pkg::*;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
        localparam int SLOT_OFF = REG_BYTES * (i - ones_below(64'(RESERVED_MASK), i));
        if (RESERVED_MASK[i]) begin : g_none
            assign hit[i] = 1'b0;
        end else begin : g_cmp
            assign hit[i] = (addr == ADDR_W'(SLOT_OFF));
        end
    end

    assign any_hit = |hit;

    // R3: the packed slot table never maps two outputs to one address
    always_comb begin
        a_r3_unique_slot: assert ($onehot0(hit));
    end

endmodule

// File: rtl/xbar_route_regs.sv
module xbar_route_regs #(
    parameter int                 NUM_OUT       = 8,
    parameter int                 NUM_SRC       = 16,
    parameter int                 SRC_W         = 4,
    parameter int                 DATA_W        = 16,
    parameter logic [NUM_OUT-1:0] RESERVED_MASK = '0,
    parameter logic [NUM_OUT-1:0] BYPASS_MASK   = '0,
    parameter int                 SAFE_SRC      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_OUT-1:0] wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SRC_W-1:0]  sel [NUM_OUT],
    output logic              data_ok
);
    localparam logic [NUM_OUT-1:0] PROG_MASK = ~(RESERVED_MASK | BYPASS_MASK);

    logic [NUM_OUT-1:0] load;

    assign data_ok = ({{(33-DATA_W){1'b0}}, wr_data} < 33'(NUM_SRC));

    always_comb begin
        load = wr_hit & PROG_MASK & {NUM_OUT{wr_en & data_ok}};
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_reg
        if (RESERVED_MASK[i]) begin : g_rsv
            assign sel[i] = '0;
        end else if (BYPASS_MASK[i]) begin : g_byp
            assign sel[i] = SRC_W'(i);
        end else begin : g_prog
            logic [SRC_W-1:0] sel_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sel_q <= SRC_W'(SAFE_SRC);
                end else if (load[i]) begin
                    sel_q <= wr_data[SRC_W-1:0];
                end
            end
            assign sel[i] = sel_q;

            // R4: a valid write to this slot lands in the next cycle
            a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_hit[i] && data_ok) |=> (sel[i] == $past(wr_data[SRC_W-1:0])));

            // R5: an out-of-range source leaves the selection alone
            a_r5_bad_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !data_ok) |=> $stable(sel[i]));
        end
    end

endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
    parameter int                 NUM_OUT       = 8,
    parameter int                 NUM_SRC       = 16,
    parameter int                 SRC_W         = 4,
    parameter logic [NUM_OUT-1:0] RESERVED_MASK = '0
) (
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [SRC_W-1:0]   sel [NUM_OUT],
    output logic [NUM_OUT-1:0] out_irq
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_mux
        assign out_irq[i] = src_irq[sel[i]] & ~RESERVED_MASK[i];
    end

endmodule

// File: rtl/xbar_irq_router.sv
module xbar_irq_router #(
    parameter int                 NUM_SRC       = 16,
    parameter int                 NUM_OUT       = 8,
    parameter int                 REG_BYTES     = 2,
    parameter int                 ADDR_W        = 8,
    parameter logic [NUM_OUT-1:0] RESERVED_MASK = 8'b0001_0010,
    parameter logic [NUM_OUT-1:0] BYPASS_MASK   = 8'b0100_0000,
    parameter int                 SAFE_SRC      = 15,
    localparam int                DATA_W        = REG_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic [NUM_OUT-1:0] out_irq,
    output logic               err_flag
);
    import xbar_pkg::*;

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // R2: only byte, half-word and word registers are allowed
    if (!(REG_BYTES == 1 || REG_BYTES == 2 || REG_BYTES == 4)) begin : g_bad_width
        $error("xbar_irq_router: REG_BYTES must be 1, 2 or 4");
    end

    logic [NUM_OUT-1:0] wr_hit;
    logic               wr_any;
    logic [NUM_OUT-1:0] rd_hit;
    logic               rd_any;
    logic [SRC_W-1:0]   sel [NUM_OUT];
    logic               data_ok;
    logic               bad_write;

    xbar_slot_decode #(
        .NUM_OUT(NUM_OUT), .REG_BYTES(REG_BYTES), .ADDR_W(ADDR_W),
        .RESERVED_MASK(RESERVED_MASK)
    ) i_wr_decode (
        .addr(wr_addr), .hit(wr_hit), .any_hit(wr_any)
    );

    xbar_slot_decode #(
        .NUM_OUT(NUM_OUT), .REG_BYTES(REG_BYTES), .ADDR_W(ADDR_W),
        .RESERVED_MASK(RESERVED_MASK)
    ) i_rd_decode (
        .addr(rd_addr), .hit(rd_hit), .any_hit(rd_any)
    );

    xbar_route_regs #(
        .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .DATA_W(DATA_W),
        .RESERVED_MASK(RESERVED_MASK), .BYPASS_MASK(BYPASS_MASK),
        .SAFE_SRC(SAFE_SRC)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hit(wr_hit),
        .wr_data(wr_data), .sel(sel), .data_ok(data_ok)
    );

    xbar_out_mux #(
        .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W),
        .RESERVED_MASK(RESERVED_MASK)
    ) i_mux (
        .src_irq(src_irq), .sel(sel), .out_irq(out_irq)
    );

    // read port: OR of the single hit slot, zero when nothing matches
    always_comb begin
        rd_data = '0;
        if (rd_any) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                if (rd_hit[i]) rd_data = rd_data | DATA_W'(sel[i]);
            end
        end
    end

    // sticky error machine
    err_state_e err_q, err_d;

    assign bad_write = wr_en && (!wr_any || !data_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= ERR_CLEAR;
        else        err_q <= err_d;
    end

    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR:   if (bad_write) err_d = ERR_LATCHED;
            ERR_LATCHED: err_d = ERR_LATCHED;
            default:     err_d = ERR_LATCHED;
        endcase
    end

    assign err_flag = (err_q == ERR_LATCHED);

    // R6: a write that matches no slot raises the flag
    a_r6_unmapped_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_any) |=> err_flag);

    // R5: an out-of-range source raises the flag
    a_r5_range_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !data_ok) |=> err_flag);

    // R9: the flag never drops before reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

// File: tb/test_xbar_irq_router.sv
`timescale 1ns/1ps
module test_xbar_irq_router;

    localparam int NUM_SRC = 16;
    localparam int NUM_OUT = 8;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int NVEC    = 6;

    // table: output index, slot address, source written
    localparam int V_IDX  [NVEC] = '{0, 2, 3, 5, 7, 0};
    localparam int V_ADDR [NVEC] = '{0, 2, 4, 6, 10, 0};
    localparam int V_DATA [NVEC] = '{3, 9, 0, 14, 1, 12};

    localparam int PROG_ADDR [5] = '{0, 2, 4, 6, 10};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n   = 1'b0;
    logic               wr_en   = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [DATA_W-1:0]  rd_data;
    logic [NUM_SRC-1:0] src_irq = '0;
    logic [NUM_OUT-1:0] out_irq;
    logic               err_flag;

    xbar_irq_router i_xbar_irq_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_irq(src_irq), .out_irq(out_irq), .err_flag(err_flag)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic do_write(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd_check(input int addr, input int exp, input string tag);
        rd_addr = ADDR_W'(addr);
        #1;
        check(rd_data == DATA_W'(exp), tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic all_safe(input string tag);
        for (int k = 0; k < 5; k++) rd_check(PROG_ADDR[k], 15, tag);
    endtask

    initial begin
        do_reset();

        // R1: safe routing after reset
        all_safe("R1 reset readback");
        check(err_flag == 1'b0, "R1 err after reset", 32'(err_flag), 0);
        src_irq = 16'h8000; #1;
        check(out_irq == 8'b1010_1101, "R1 safe source routing", 32'(out_irq), 32'hAD);

        // R8: reserved outputs stay low
        src_irq = '1; #1;
        check(out_irq == 8'b1110_1101, "R8 reserved low with all sources high",
              32'(out_irq), 32'hED);

        // R7: bypass output follows source 6 and ignores writes
        src_irq = 16'h0040; #1;
        check(out_irq == 8'b0100_0000, "R7 bypass routing", 32'(out_irq), 32'h40);
        do_write(8, 3);
        rd_check(8, 6, "R7 bypass slot readback");
        check(out_irq == 8'b0100_0000, "R7 bypass unchanged after write",
              32'(out_irq), 32'h40);
        check(err_flag == 1'b0, "R7 bypass write no error", 32'(err_flag), 0);

        // R10: unmapped reads return zero
        rd_check(1, 0, "R10 misaligned read");
        rd_check(3, 0, "R10 misaligned read");
        rd_check(12, 0, "R10 past last slot read");

        // table walk: R2 R3 R4 R11
        for (int v = 0; v < NVEC; v++) begin
            do_write(V_ADDR[v], V_DATA[v]);
            rd_check(V_ADDR[v], V_DATA[v], "R2 R3 R4 slot readback");
            src_irq = NUM_SRC'(1) << V_DATA[v]; #1;
            check(out_irq[V_IDX[v]] == 1'b1, "R4 R11 output high with source",
                  32'(out_irq), 32'(V_IDX[v]));
            src_irq = ~(NUM_SRC'(1) << V_DATA[v]); #1;
            check(out_irq[V_IDX[v]] == 1'b0, "R11 output low with source",
                  32'(out_irq), 32'(V_IDX[v]));
        end
        check(err_flag == 1'b0, "R4 valid writes leave flag clear", 32'(err_flag), 0);

        // R12: release back to safe source
        do_write(0, 15);
        rd_check(0, 15, "R12 release readback");
        src_irq = 16'h8000; #1;
        check(out_irq[0] == 1'b1, "R12 released output on safe source",
              32'(out_irq), 32'h1);

        // R5: out-of-range source
        do_write(2, 16);
        rd_check(2, 9, "R5 out of range ignored");
        check(err_flag == 1'b1, "R5 error flag", 32'(err_flag), 1);

        // R9: sticky through a valid write
        do_write(4, 7);
        rd_check(4, 7, "R9 valid write after error");
        check(err_flag == 1'b1, "R9 flag sticky", 32'(err_flag), 1);
        do_reset();
        check(err_flag == 1'b0, "R9 reset clears flag", 32'(err_flag), 0);

        // R6: write past last slot
        do_write(12, 5);
        check(err_flag == 1'b1, "R6 unmapped write flag", 32'(err_flag), 1);
        all_safe("R6 unmapped write ignored");

        // R6: misaligned write
        do_reset();
        do_write(3, 5);
        check(err_flag == 1'b1, "R6 misaligned write flag", 32'(err_flag), 1);
        rd_check(2, 15, "R6 misaligned neighbour low");
        rd_check(4, 15, "R6 misaligned neighbour high");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule